// File: doc/BRIEF.md
# Program/Erase Status Flag Generator

This block builds the status word a flash array returns on reads while an embedded program or erase operation is running, or while an erase is suspended. The operation controller supplies its current state: program busy, erase busy, erase-block window open, erase suspended, operation failed and an abort pulse for an erase whose selected blocks were all protected. It also supplies the data bit being programmed and a map of the blocks under erase. The read path supplies the block of the read address and a read strobe.

The block produces an 8-bit status word, a select flag and a ready level. When the select flag is high, the read mux returns the status word. When it is low, the mux returns array data. The two toggle bits let software detect a running operation by reading twice. One toggle bit moves only for reads of blocks under erase, so it also identifies which block is erasing.

Top module: `pe_status_gen`

## Requirements
- R1: While `prog_busy` is high, `stat_sel` is 1 and bit 7 equals the inverse of `prog_bit`. Once `prog_busy` falls with the other state inputs low, `stat_sel` returns to 0 (array data).
- R2: While `erase_busy` is high and no program runs, bit 7 reads 0 and `stat_sel` is 1.
- R3: Bit 6 inverts once per rising edge of `rd_strobe` while an operation runs (`rdy` low). A strobe held high over further cycles causes no further inversion.
- R4: Bit 6 keeps its value across reads while the block is idle or only suspended.
- R5: During erase or erase suspend, bit 2 inverts once per rising edge of `rd_strobe` when `rd_blk` indexes a set bit of `erase_map`. Reads of other blocks leave bit 2 unchanged.
- R6: Bit 5 equals `op_fail`.
- R7: During erase, bit 3 is 0 while `erase_win` is high and 1 once it is low.
- R8: With `erase_susp` high and no program or erase running, a read of a block in `erase_map` gives `stat_sel` = 1 and bit 7 = 1. A read of any other block gives `stat_sel` = 0.
- R9: After a one-cycle `prot_abort` pulse, `stat_sel` = 1, bit 7 = 0 and `rdy` = 0 for exactly `WAIT_CYCLES` cycles. After that window, `stat_sel` returns to 0.
- R10: `rdy` is 0 while a program, an erase or an abort window is active. It is 1 when idle or suspended.
- R11: Bits 0, 1 and 4 of `stat` always read 0.
- R12: After reset with all inputs low, `stat` is 0, `stat_sel` is 0 and `rdy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_busy | input | 1 | Program operation running |
| erase_busy | input | 1 | Erase operation running (window or erasing) |
| erase_win | input | 1 | Window for adding erase blocks still open |
| erase_susp | input | 1 | Erase suspended |
| op_fail | input | 1 | Operation failed |
| prot_abort | input | 1 | One-cycle pulse: all selected erase blocks protected |
| prog_bit | input | 1 | Bit 7 of the data being programmed |
| erase_map | input | NB | One bit per block under erase |
| rd_blk | input | BW | Block index of the read address |
| rd_strobe | input | 1 | Read access strobe |
| stat | output | 8 | Status word |
| stat_sel | output | 1 | Return `stat` instead of array data |
| rdy | output | 1 | Ready (1) / busy (0) |

## Verification
The bench holds `rd_strobe` high across several clocks to catch a toggle that moves on level instead of edge. A design making that mistake would make bit 6 run away during a single long read. It alternates reads between an erasing block and a non-erasing block. A design that ignores the block map would move bit 2 on every read and lose the identification of the erasing block. It checks that bit 6 freezes under suspend, that bit 7 reads 1 on the suspended block while other blocks fall back to array data, and that the protected-abort window lasts exactly its parameterised length. An off-by-one counter would show up there as one cycle too many or too few.

// File: rtl/pe_status_gen.sv
module pe_status_gen #(
  parameter int NB          = 11,
  parameter int WAIT_CYCLES = 12500,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int CW = $clog2(WAIT_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_busy,
  input  logic          erase_busy,
  input  logic          erase_win,
  input  logic          erase_susp,
  input  logic          op_fail,
  input  logic          prot_abort,
  input  logic          prog_bit,
  input  logic [NB-1:0] erase_map,
  input  logic [BW-1:0] rd_blk,
  input  logic          rd_strobe,
  output logic [7:0]    stat,
  output logic          stat_sel,
  output logic          rdy
);

  logic          rd_q, tgl6, tgl2;
  logic [CW-1:0] abort_cnt;

  wire abort_on = (abort_cnt != '0);
  wire running  = prog_busy | erase_busy | abort_on;
  wire in_blk   = |(erase_map & (NB'(1) << rd_blk));
  wire rd_rise  = rd_strobe & ~rd_q;
  wire susp_hit = erase_susp & in_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      tgl6      <= 1'b0;
      tgl2      <= 1'b0;
      abort_cnt <= '0;
    end else begin
      rd_q <= rd_strobe;
      if (rd_rise && running)
        tgl6 <= ~tgl6;
      if (rd_rise && (erase_busy || erase_susp) && in_blk)
        tgl2 <= ~tgl2;
      if (prot_abort)
        abort_cnt <= CW'(WAIT_CYCLES);
      else if (abort_on)
        abort_cnt <= abort_cnt - 1'b1;
    end
  end

  logic poll;
  always_comb begin
    if (prog_busy)                    poll = ~prog_bit;
    else if (erase_busy || abort_on)  poll = 1'b0;
    else if (susp_hit)                poll = 1'b1;
    else                              poll = 1'b0;
  end

  wire timer_bit = (erase_busy & ~erase_win) | abort_on;

  assign stat     = {poll, tgl6, op_fail, 1'b0, timer_bit, tgl2, 2'b00};
  assign stat_sel = running | susp_hit;
  assign rdy      = ~running;

endmodule

// File: rtl/pe_status_chk.sv
module pe_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_busy,
  input logic       erase_busy,
  input logic       erase_susp,
  input logic       op_fail,
  input logic       prot_abort,
  input logic       prog_bit,
  input logic       rd_strobe,
  input logic [7:0] stat,
  input logic       stat_sel,
  input logic       rdy
);

  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |-> (stat_sel && stat[7] == !prog_bit)); // R1

  AST_TGL6_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_strobe) && !rdy) |=> (stat[6] != $past(stat[6]))); // R3

  AST_TGL6_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && $past(rd_strobe)) |=> $stable(stat[6])); // R3

  AST_TGL6_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> $stable(stat[6])); // R4

  AST_TGL2_NOERASE: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_busy || erase_susp) |=> $stable(stat[2])); // R5

  AST_FAIL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    op_fail |-> stat[5]); // R6

  AST_SUSP_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_susp && !prog_busy && rdy && stat_sel) |-> stat[7]); // R8

  AST_ABORT_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(prot_abort) && !prog_busy) |-> (stat_sel && !stat[7] && !rdy)); // R9

endmodule

bind pe_status_gen pe_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .erase_busy(erase_busy),
  .erase_susp(erase_susp), .op_fail(op_fail), .prot_abort(prot_abort),
  .prog_bit(prog_bit), .rd_strobe(rd_strobe), .stat(stat),
  .stat_sel(stat_sel), .rdy(rdy)
);

// File: tb/pe_status_gen_test.sv
module pe_status_gen_test;
  localparam int NB = 11;
  localparam int BW = $clog2(NB);
  localparam int WAITC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_busy = 0, erase_busy = 0, erase_win = 0, erase_susp = 0;
  logic op_fail = 0, prot_abort = 0, prog_bit = 0, rd_strobe = 0;
  logic [NB-1:0] erase_map = '0;
  logic [BW-1:0] rd_blk = '0;
  logic [7:0] stat;
  logic stat_sel, rdy;

  int n_run = 0, n_fail = 0;
  logic e6 = 0, e2 = 0;

  always #4 clk = ~clk;

  pe_status_gen #(.NB(NB), .WAIT_CYCLES(WAITC)) uut (
    .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .erase_busy(erase_busy),
    .erase_win(erase_win), .erase_susp(erase_susp), .op_fail(op_fail),
    .prot_abort(prot_abort), .prog_bit(prog_bit), .erase_map(erase_map),
    .rd_blk(rd_blk), .rd_strobe(rd_strobe), .stat(stat),
    .stat_sel(stat_sel), .rdy(rdy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_rsvd();
    chk(stat[1:0] == 2'b00 && stat[4] == 1'b0, "R11", {stat[4], stat[1:0]}, 0);
  endtask

  // one read access; strobe held for 'hold' cycles; model updates on leading edge only
  task automatic do_read(input int blk, input int hold);
    bit run, hit;
    @(negedge clk);
    rd_blk = BW'(blk);
    rd_strobe = 1'b1;
    run = prog_busy | erase_busy;
    hit = (erase_busy | erase_susp) & erase_map[blk];
    if (run) e6 = ~e6;
    if (hit) e2 = ~e2;
    for (int i = 0; i < hold; i++) @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic t_reset();
    chk(stat == 8'h00, "R12 stat", stat, 0);
    chk(stat_sel == 0 && rdy == 1, "R12 sel/rdy", {stat_sel, rdy}, 1);
  endtask

  task automatic t_program();
    @(negedge clk);
    prog_busy = 1; prog_bit = 1;
    @(negedge clk);
    chk(stat[7] == 0 && stat_sel, "R1 poll inv of 1", {stat_sel, stat[7]}, 2);
    chk(rdy == 0, "R10 busy in program", rdy, 0);
    for (int k = 0; k < 3; k++) begin
      do_read(0, 1);
      chk(stat[6] == e6, "R3 toggle per read", stat[6], e6);
      chk_rsvd();
    end
    do_read(0, 4);
    chk(stat[6] == e6, "R3 held strobe flips once", stat[6], e6);
    prog_bit = 0;
    #1;
    chk(stat[7] == 1, "R1 poll inv of 0", stat[7], 1);
    @(negedge clk);
    prog_busy = 0;
    #1;
    chk(stat_sel == 0 && rdy == 1, "R1 done gives array data", {stat_sel, rdy}, 1);
    do_read(0, 1);
    chk(stat[6] == e6, "R4 idle no toggle", stat[6], e6);
  endtask

  task automatic t_erase();
    @(negedge clk);
    erase_map = '0; erase_map[3] = 1; erase_map[5] = 1;
    erase_busy = 1; erase_win = 1;
    @(negedge clk);
    chk(stat[7] == 0 && stat_sel, "R2 erase poll", {stat_sel, stat[7]}, 2);
    chk(stat[3] == 0, "R7 window open", stat[3], 0);
    erase_win = 0;
    @(negedge clk);
    chk(stat[3] == 1, "R7 window closed", stat[3], 1);
    chk(rdy == 0, "R10 busy in erase", rdy, 0);
    do_read(3, 1);
    chk(stat[2] == e2, "R5 erasing block toggles", stat[2], e2);
    chk(stat[6] == e6, "R3 erase toggle", stat[6], e6);
    do_read(4, 1);
    chk(stat[2] == e2, "R5 other block no toggle", stat[2], e2);
    chk(stat[6] == e6, "R3 erase toggle other", stat[6], e6);
    do_read(5, 3);
    chk(stat[2] == e2, "R5 second erasing block", stat[2], e2);
    chk_rsvd();
    op_fail = 1;
    #1;
    chk(stat[5] == 1, "R6 fail set", stat[5], 1);
    @(negedge clk);
    op_fail = 0;
    #1;
    chk(stat[5] == 0, "R6 fail clear", stat[5], 0);
  endtask

  task automatic t_suspend();
    @(negedge clk);
    erase_busy = 0; erase_susp = 1;
    @(negedge clk);
    chk(rdy == 1, "R10 ready in suspend", rdy, 1);
    do_read(3, 1);
    chk(stat_sel && stat[7], "R8 suspended block poll", {stat_sel, stat[7]}, 3);
    chk(stat[2] == e2, "R5 toggle in suspend", stat[2], e2);
    chk(stat[6] == e6, "R4 bit6 frozen in suspend", stat[6], e6);
    rd_blk = BW'(4);
    #1;
    chk(stat_sel == 0, "R8 other block array data", stat_sel, 0);
    do_read(4, 1);
    chk(stat[2] == e2, "R5 no toggle other block suspended", stat[2], e2);
    @(negedge clk);
    erase_susp = 0; erase_map = '0;
  endtask

  task automatic t_abort();
    int cnt;
    bit bad;
    @(negedge clk);
    prot_abort = 1;
    @(negedge clk);
    prot_abort = 0;
    cnt = 0; bad = 0;
    while (stat_sel && cnt < 100) begin
      if (stat[7] != 0 || rdy != 0) bad = 1;
      cnt++;
      @(negedge clk);
    end
    chk(cnt == WAITC, "R9 abort window length", cnt, WAITC);
    chk(!bad, "R9 poll 0 and busy in window", bad, 0);
    chk(stat_sel == 0 && rdy == 1, "R9 released", {stat_sel, rdy}, 1);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_suspend();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule